// File: doc/BRIEF.md
# Double-Buffered Display Window Register Bank

This block is the configuration store of a display controller that composes three overlay windows under one general (display-wide) group. Every configuration register is held twice. Software writes a pending copy over a simple single-cycle register bus. The display pipeline sees only the active copy. The active copy changes only at a vertical blank, so the pipeline never sees a frame built from half-old and half-new settings.

All windows share one address range for their per-window registers. A one-hot header register decides which window's pending set that range reaches. Software commits a group in two steps:

1. It writes the group's update (arm) bit in the state-control register.
2. In a later write, it sets the same group's activation-request bit.

At the next vertical-blank pulse, every pending register of each requesting group is copied to the active side in one clock edge. The request and arm bits of that group then clear. A read-select bit chooses whether readback of double-buffered registers returns the pending or the active copy.

The block also collects interrupts from vertical blank, frame end, and per-window underflow and overflow. Each source has its own polarity and level/edge setting. The status bits are sticky and write-one-to-clear. Separate enable and mask registers gate the readback and the interrupt line.

Top module: `dbuf_win_regs`

## Requirements
- R1: After reset, every register, the arm and request bits, all active outputs, `bus_rdata` for any address, and `irq_o` are zero.
- R2: The header (address 0x00) holds a one-hot window select: bit 0 selects window A, bit 1 selects B and bit 2 selects C. A header write whose value is neither one-hot nor zero is ignored. With a zero header, window-range writes are dropped and window-range reads return 0.
- R3: Writes to the window range (0x20 options, 0x21 base address, 0x22 position, 0x23 size) reach only the pending copy of the selected window. Active copies and active outputs of all windows do not change until a promotion.
- R4: In state control (0x01), bit 0 arms the general group and bits 1..3 arm windows A..C. Bit 8 requests activation for the general group and bits 9..11 for windows A..C. A request bit is taken only for a group that was already armed before that write. A request for an unarmed group, including one made in the same write that arms it, has no effect.
- R5: On a clock edge where `vblank_i` is high, each group with a pending request copies all of its pending registers to its active copy, and its arm and request bits clear. Groups without a request keep their active values.
- R6: A pending write in a promoting vblank cycle leaves the old pending value in the active copy and the new value in the pending copy. A request written in a vblank cycle is not served at that vblank, but at the next one.
- R7: When access-select bit 0 (0x02) is 1, reads of double-buffered registers (0x10 general configuration and the window range) return the active copy; when it is 0 they return the pending copy.
- R8: Interrupt source bits are: 0 frame end, 1 vblank, 2..4 underflow A..C, 5..7 overflow A..C. A polarity bit of 1 (0x07) inverts its source. A type bit of 1 (0x06) makes the source capture on a rising edge; a type bit of 0 makes it capture in every cycle the source is active. Captured status bits stay set.
- R9: Writing 1 to a status bit (0x03) clears it. A capture in the same cycle as the clear wins, so the bit stays set.
- R10: A status read returns the raw status ANDed with the enable register (0x04). `irq_o` is high when any bit is set in status, enable and mask (0x05) at once.
- R11: `win_en_o[w]` follows bit 0 of window w's active options register. Clearing that bit and committing it hides the window at the next vblank.
- R12: A state-control read returns the arm bits in bits 0..3 and the request bits in bits 8..11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| vblank_i | input | 1 | Vertical-blank pulse; promotion point and interrupt source |
| frame_end_i | input | 1 | Frame-end interrupt source |
| underflow_i | input | 3 | Per-window underflow sources, bit 0 = window A |
| overflow_i | input | 3 | Per-window overflow sources, bit 0 = window A |
| irq_o | output | 1 | Interrupt line |
| gen_cfg_o | output | 32 | Active general configuration word |
| win_en_o | output | 3 | Active window enable, bit 0 = window A |
| win_base_o | output | 96 | Active base addresses, 32 bits per window, A lowest |
| win_pos_o | output | 96 | Active positions, 32 bits per window |
| win_size_o | output | 96 | Active sizes, 32 bits per window |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a vblank promotion and a bus write to the same group: either a pending write or an activation request. The second pair is a status capture and a write-one-to-clear of the same bit. The bench holds `vblank_i` high in exactly the cycle it writes the general configuration register, and then again in the cycle it writes a request. It judges the outcome from `gen_cfg_o`, the pending readback and the state-control readback. It also raises frame end in the cycle it clears that status bit, and expects the bit to read back set.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  // register word addresses
  localparam int A_HDR  = 'h00;
  localparam int A_STC  = 'h01;
  localparam int A_ACC  = 'h02;
  localparam int A_IST  = 'h03;
  localparam int A_IEN  = 'h04;
  localparam int A_IMK  = 'h05;
  localparam int A_ITY  = 'h06;
  localparam int A_IPL  = 'h07;
  localparam int A_GCFG = 'h10;
  localparam int A_WIN  = 'h20;
  // request field offset in the state-control word
  localparam int ACT_OFS = 8;

  // per-window register slots inside the window range
  typedef enum logic [1:0] {
    WR_OPT  = 2'd0,
    WR_BASE = 2'd1,
    WR_POS  = 2'd2,
    WR_SIZE = 2'd3
  } wreg_e;
endpackage

// File: rtl/dbr_group.sv
module dbr_group #(
  parameter int NREG = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              promote,
  output logic [NREG*DW-1:0] pend_o,
  output logic [NREG*DW-1:0] act_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] pend_q;
    logic [DW-1:0] act_q;

    always_ff @(posedge clk) begin
      if (!rst_n)        pend_q <= '0;
      else if (wr_en[r]) pend_q <= wdata;
    end

    // the copy takes the value held before any same-edge write
    always_ff @(posedge clk) begin
      if (!rst_n)       act_q <= '0;
      else if (promote) act_q <= pend_q;
    end

    assign pend_o[r*DW +: DW] = pend_q;
    assign act_o[r*DW +: DW]  = act_q;
  end
endmodule

// File: rtl/dbr_state_ctl.sv
module dbr_state_ctl #(
  parameter int NGRP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NGRP-1:0] arm_w,
  input  logic [NGRP-1:0] act_w,
  input  logic            vblank,
  output logic [NGRP-1:0] armed_o,
  output logic [NGRP-1:0] req_o,
  output logic [NGRP-1:0] promote_o
);
  logic [NGRP-1:0] armed_q, req_q;
  logic [NGRP-1:0] keep_arm, new_req;

  assign promote_o = req_q & {NGRP{vblank}};
  // arming consumed by a promotion on this edge cannot back a new request
  assign keep_arm  = armed_q & ~promote_o;
  assign new_req   = wr ? (act_w & keep_arm) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= '0;
      req_q   <= '0;
    end else begin
      armed_q <= keep_arm | (wr ? arm_w : '0);
      req_q   <= (req_q & ~promote_o) | new_req;
    end
  end

  assign armed_o = armed_q;
  assign req_o   = req_q;
endmodule

// File: rtl/dbr_irq.sv
module dbr_irq #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] wdata,
  input  logic            wr_st,
  input  logic            wr_en,
  input  logic            wr_mk,
  input  logic            wr_ty,
  input  logic            wr_pl,
  output logic [NSRC-1:0] st_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] mk_o,
  output logic [NSRC-1:0] ty_o,
  output logic [NSRC-1:0] pl_o,
  output logic            irq_o
);
  logic [NSRC-1:0] st_q, en_q, mk_q, ty_q, pl_q, prev_q;
  logic [NSRC-1:0] adj, hit, clr;

  assign adj = src_i ^ pl_q;
  assign hit = (ty_q & adj & ~prev_q) | (~ty_q & adj);
  assign clr = wr_st ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      mk_q   <= '0;
      ty_q   <= '0;
      pl_q   <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= adj;
      st_q   <= (st_q & ~clr) | hit;
      if (wr_en) en_q <= wdata;
      if (wr_mk) mk_q <= wdata;
      if (wr_ty) ty_q <= wdata;
      if (wr_pl) pl_q <= wdata;
    end
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign mk_o  = mk_q;
  assign ty_o  = ty_q;
  assign pl_o  = pl_q;
  assign irq_o = |(st_q & en_q & mk_q);
endmodule

// File: rtl/dbuf_win_regs.sv
module dbuf_win_regs
  import dbr_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NWREG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_we,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 vblank_i,
  input  logic                 frame_end_i,
  input  logic [NWIN-1:0]      underflow_i,
  input  logic [NWIN-1:0]      overflow_i,
  output logic                 irq_o,
  output logic [DW-1:0]        gen_cfg_o,
  output logic [NWIN-1:0]      win_en_o,
  output logic [NWIN*DW-1:0]   win_base_o,
  output logic [NWIN*DW-1:0]   win_pos_o,
  output logic [NWIN*DW-1:0]   win_size_o
);
  localparam int NGRP = NWIN + 1;
  localparam int NSRC = 2 + 2 * NWIN;
  localparam int RW   = $clog2(NWREG);

  // ---------------- address decode ----------------
  logic hit_hdr, hit_stc, hit_acc, hit_ist, hit_ien, hit_imk, hit_ity, hit_ipl, hit_gcfg;
  logic in_win;
  logic [RW-1:0] wofs;

  assign hit_hdr  = bus_addr == AW'(A_HDR);
  assign hit_stc  = bus_addr == AW'(A_STC);
  assign hit_acc  = bus_addr == AW'(A_ACC);
  assign hit_ist  = bus_addr == AW'(A_IST);
  assign hit_ien  = bus_addr == AW'(A_IEN);
  assign hit_imk  = bus_addr == AW'(A_IMK);
  assign hit_ity  = bus_addr == AW'(A_ITY);
  assign hit_ipl  = bus_addr == AW'(A_IPL);
  assign hit_gcfg = bus_addr == AW'(A_GCFG);
  assign in_win   = (bus_addr >= AW'(A_WIN)) && (bus_addr < AW'(A_WIN + NWREG));
  assign wofs     = RW'(bus_addr - AW'(A_WIN));

  // ---------------- window header and access select ----------------
  logic [NWIN-1:0] hdr_q;
  logic [NWIN-1:0] hdr_wv;
  logic            hdr_ok;
  logic            acc_q;

  assign hdr_wv = bus_wdata[NWIN-1:0];
  assign hdr_ok = ((hdr_wv & (hdr_wv - NWIN'(1))) == '0) && (bus_wdata[DW-1:NWIN] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      acc_q <= 1'b0;
    end else begin
      if (bus_we && hit_hdr && hdr_ok) hdr_q <= hdr_wv;
      if (bus_we && hit_acc)           acc_q <= bus_wdata[0];
    end
  end

  // ---------------- arm / request handshake ----------------
  logic [NGRP-1:0] armed, req, promote;

  dbr_state_ctl #(.NGRP(NGRP)) u_stc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_we && hit_stc),
    .arm_w     (bus_wdata[NGRP-1:0]),
    .act_w     (bus_wdata[ACT_OFS +: NGRP]),
    .vblank    (vblank_i),
    .armed_o   (armed),
    .req_o     (req),
    .promote_o (promote)
  );

  // ---------------- general group ----------------
  logic [DW-1:0] gpend, gact;

  dbr_group #(.NREG(1), .DW(DW)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && hit_gcfg),
    .wdata   (bus_wdata),
    .promote (promote[0]),
    .pend_o  (gpend),
    .act_o   (gact)
  );
  assign gen_cfg_o = gact;

  // ---------------- window groups ----------------
  logic [NWREG*DW-1:0] wpend [NWIN];
  logic [NWREG*DW-1:0] wact  [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [NWREG-1:0] wen;

    always_comb begin
      for (int r = 0; r < NWREG; r++)
        wen[r] = bus_we && in_win && hdr_q[w] && (wofs == RW'(r));
    end

    dbr_group #(.NREG(NWREG), .DW(DW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wen),
      .wdata   (bus_wdata),
      .promote (promote[w+1]),
      .pend_o  (wpend[w]),
      .act_o   (wact[w])
    );

    assign win_en_o[w]            = wact[w][int'(WR_OPT) * DW];
    assign win_base_o[w*DW +: DW] = wact[w][int'(WR_BASE) * DW +: DW];
    assign win_pos_o[w*DW +: DW]  = wact[w][int'(WR_POS)  * DW +: DW];
    assign win_size_o[w*DW +: DW] = wact[w][int'(WR_SIZE) * DW +: DW];
  end

  // ---------------- interrupts ----------------
  logic [NSRC-1:0] ist, ien, imk, ity, ipl;

  dbr_irq #(.NSRC(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i ({overflow_i, underflow_i, vblank_i, frame_end_i}),
    .wdata (bus_wdata[NSRC-1:0]),
    .wr_st (bus_we && hit_ist),
    .wr_en (bus_we && hit_ien),
    .wr_mk (bus_we && hit_imk),
    .wr_ty (bus_we && hit_ity),
    .wr_pl (bus_we && hit_ipl),
    .st_o  (ist),
    .en_o  (ien),
    .mk_o  (imk),
    .ty_o  (ity),
    .pl_o  (ipl),
    .irq_o (irq_o)
  );

  // ---------------- readback ----------------
  always_comb begin
    bus_rdata = '0;
    if (hit_hdr) begin
      bus_rdata[NWIN-1:0] = hdr_q;
    end else if (hit_stc) begin
      bus_rdata[NGRP-1:0]        = armed;
      bus_rdata[ACT_OFS +: NGRP] = req;
    end else if (hit_acc) begin
      bus_rdata[0] = acc_q;
    end else if (hit_ist) begin
      bus_rdata[NSRC-1:0] = ist & ien;
    end else if (hit_ien) begin
      bus_rdata[NSRC-1:0] = ien;
    end else if (hit_imk) begin
      bus_rdata[NSRC-1:0] = imk;
    end else if (hit_ity) begin
      bus_rdata[NSRC-1:0] = ity;
    end else if (hit_ipl) begin
      bus_rdata[NSRC-1:0] = ipl;
    end else if (hit_gcfg) begin
      bus_rdata = acc_q ? gact : gpend;
    end else if (in_win) begin
      for (int w = 0; w < NWIN; w++)
        if (hdr_q[w])
          bus_rdata = acc_q ? wact[w][wofs*DW +: DW] : wpend[w][wofs*DW +: DW];
    end
  end
endmodule

// File: rtl/dbr_chk.sv
module dbr_chk #(
  parameter int NWIN = 3,
  parameter int DW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vblank,
  input logic [NWIN:0]      armed,
  input logic [NWIN:0]      req,
  input logic [NWIN-1:0]    hdr,
  input logic [DW-1:0]      gpend,
  input logic [DW-1:0]      gact,
  input logic [NWIN-1:0]    wen,
  input logic [NWIN*DW-1:0] wbase,
  input logic [NWIN*DW-1:0] wpos,
  input logic [NWIN*DW-1:0] wsize
);
  // R4: a request never exists for an unarmed group
  assert_req_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~armed) == '0);

  // R2: the header never holds more than one window
  assert_hdr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hdr));

  // R5: every request present at a vblank edge is consumed by it
  assert_req_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (req & $past(req)) == '0);

  // R5: a served general request copies the pending word
  assert_gen_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && req[0]) |=> gact == $past(gpend));

  // R3: active outputs move only on a vblank edge
  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> ($stable(gact) && $stable(wen) && $stable(wbase) &&
                 $stable(wpos) && $stable(wsize)));
endmodule

bind dbuf_win_regs dbr_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .vblank (vblank_i),
  .armed  (armed),
  .req    (req),
  .hdr    (hdr_q),
  .gpend  (gpend),
  .gact   (gact),
  .wen    (win_en_o),
  .wbase  (win_base_o),
  .wpos   (win_pos_o),
  .wsize  (win_size_o)
);

// File: tb/sim_dbuf_win_regs.sv
module sim_dbuf_win_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        vblank = 1'b0;
  logic        frame_end = 1'b0;
  logic [2:0]  underflow = '0;
  logic [2:0]  overflow = '0;
  logic        irq;
  logic [31:0] gen_cfg;
  logic [2:0]  win_en;
  logic [95:0] win_base, win_pos, win_size;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbuf_win_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank_i(vblank),
    .frame_end_i(frame_end), .underflow_i(underflow), .overflow_i(overflow),
    .irq_o(irq), .gen_cfg_o(gen_cfg), .win_en_o(win_en),
    .win_base_o(win_base), .win_pos_o(win_pos), .win_size_o(win_size)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  a;
    logic [31:0] d;
    logic        vb;
    logic        chk;
    logic [31:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 32'h0,    1'b0, 1'b1, 32'h0,    8'd1},  // R1 header
    '{1'b0, 8'h10, 32'h0,    1'b0, 1'b1, 32'h0,    8'd1},  // R1 general cfg
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h0,    8'd1},  // R1 state ctrl
    '{1'b1, 8'h00, 32'h1,    1'b0, 1'b0, 32'h0,    8'd2},  // select A
    '{1'b0, 8'h00, 32'h0,    1'b0, 1'b1, 32'h1,    8'd2},  // R2
    '{1'b1, 8'h00, 32'h3,    1'b0, 1'b0, 32'h0,    8'd2},  // not one-hot
    '{1'b0, 8'h00, 32'h0,    1'b0, 1'b1, 32'h1,    8'd2},  // R2 ignored
    '{1'b1, 8'h21, 32'h1000, 1'b0, 1'b0, 32'h0,    8'd3},  // A base pending
    '{1'b0, 8'h21, 32'h0,    1'b0, 1'b1, 32'h1000, 8'd7},  // R7 pending view
    '{1'b1, 8'h02, 32'h1,    1'b0, 1'b0, 32'h0,    8'd7},
    '{1'b0, 8'h21, 32'h0,    1'b0, 1'b1, 32'h0,    8'd3},  // R3 active still 0
    '{1'b1, 8'h02, 32'h0,    1'b0, 1'b0, 32'h0,    8'd7},
    '{1'b1, 8'h00, 32'h2,    1'b0, 1'b0, 32'h0,    8'd2},  // select B
    '{1'b0, 8'h21, 32'h0,    1'b0, 1'b1, 32'h0,    8'd3},  // R3 B untouched
    '{1'b1, 8'h21, 32'h2000, 1'b0, 1'b0, 32'h0,    8'd3},
    '{1'b1, 8'h01, 32'h202,  1'b0, 1'b0, 32'h0,    8'd4},  // arm+act A together
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h2,    8'd4},  // R4 only armed
    '{1'b0, 8'h01, 32'h0,    1'b1, 1'b1, 32'h2,    8'd4},  // R4 vblank, no request
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h2,    8'd5},  // R5 still armed
    '{1'b1, 8'h01, 32'h200,  1'b0, 1'b0, 32'h0,    8'd4},  // act A
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h202,  8'd12}, // R12 readback
    '{1'b0, 8'h00, 32'h0,    1'b1, 1'b1, 32'h2,    8'd2},  // vblank, promote A
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h0,    8'd5},  // R5 bits cleared
    '{1'b1, 8'h00, 32'h1,    1'b0, 1'b0, 32'h0,    8'd2},
    '{1'b1, 8'h02, 32'h1,    1'b0, 1'b0, 32'h0,    8'd7},
    '{1'b0, 8'h21, 32'h0,    1'b0, 1'b1, 32'h1000, 8'd5},  // R5 A active
    '{1'b1, 8'h00, 32'h2,    1'b0, 1'b0, 32'h0,    8'd2},
    '{1'b0, 8'h21, 32'h0,    1'b0, 1'b1, 32'h0,    8'd5},  // R5 B not promoted
    '{1'b1, 8'h02, 32'h0,    1'b0, 1'b0, 32'h0,    8'd7},
    '{1'b1, 8'h01, 32'h400,  1'b0, 1'b0, 32'h0,    8'd4},  // act B unarmed
    '{1'b0, 8'h01, 32'h0,    1'b0, 1'b1, 32'h0,    8'd4}   // R4 ignored
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic vb = 1'b0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; vblank = vb;
    @(negedge clk);
    bus_we = 1'b0; vblank = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic vb_pulse();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 gen_cfg", gen_cfg, 32'h0);
    check("R1 win_en", {29'b0, win_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = VT[i].we; bus_addr = VT[i].a; bus_wdata = VT[i].d; vblank = VT[i].vb;
      #1;
      if (VT[i].chk) begin
        nchk++;
        if (bus_rdata !== VT[i].e) begin
          nerr++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VT[i].r, i, bus_rdata, VT[i].e);
        end
      end
    end
    @(negedge clk);
    bus_we = 1'b0; vblank = 1'b0;

    check("R5 A base out", win_base[31:0], 32'h1000);
    check("R3 B base out", win_base[63:32], 32'h0);

    // R6: pending write during a promoting vblank
    wr(8'h10, 32'hAA);
    wr(8'h01, 32'h1);
    wr(8'h01, 32'h100);
    wr(8'h10, 32'hBB, 1'b1);
    check("R6 active keeps old pending", gen_cfg, 32'hAA);
    rd(8'h10, 32'hBB, "R6 pending keeps new write");
    // R6: request written during vblank waits for the next one
    wr(8'h01, 32'h1);
    wr(8'h01, 32'h100, 1'b1);
    check("R6 late request not served", gen_cfg, 32'hAA);
    rd(8'h01, 32'h101, "R6 request still pending");
    vb_pulse();
    check("R6 served at next vblank", gen_cfg, 32'hBB);

    // R11: window C enable and hide
    wr(8'h00, 32'h4);
    wr(8'h20, 32'h1);
    wr(8'h01, 32'h8);
    wr(8'h01, 32'h800);
    vb_pulse();
    check("R11 C shown", {29'b0, win_en}, 32'h4);
    wr(8'h20, 32'h0);
    wr(8'h01, 32'h8);
    wr(8'h01, 32'h800);
    check("R3 C still shown before vblank", {29'b0, win_en}, 32'h4);
    vb_pulse();
    check("R11 C hidden", {29'b0, win_en}, 32'h0);

    // R2: zero header drops window access
    wr(8'h00, 32'h0);
    wr(8'h21, 32'hDEAD);
    rd(8'h21, 32'h0, "R2 zero header read");
    wr(8'h00, 32'h4);
    rd(8'h21, 32'h0, "R2 zero header write dropped");

    // R8..R10: interrupts
    wr(8'h04, 32'hFF);
    wr(8'h03, 32'hFF);
    rd(8'h03, 32'h0, "R9 all cleared");
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    rd(8'h03, 32'h1, "R8 frame end level capture");
    check("R10 irq masked off", {31'b0, irq}, 32'h0);
    wr(8'h05, 32'h1);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h03, 32'h0, "R10 read gated by enable");
    check("R10 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'hFF);
    // R9 collision: capture and clear on one edge
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h03; bus_wdata = 32'h1; frame_end = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; frame_end = 1'b0;
    rd(8'h03, 32'h1, "R9 capture wins over clear");
    wr(8'h03, 32'h1);
    rd(8'h03, 32'h0, "R9 clear");
    // R8 polarity
    wr(8'h07, 32'h4);
    rd(8'h03, 32'h4, "R8 inverted underflow A");
    wr(8'h07, 32'h0);
    wr(8'h03, 32'hFF);
    rd(8'h03, 32'h0, "R9 clear after polarity");
    // R8 edge type
    wr(8'h06, 32'h20);
    @(negedge clk); overflow[0] = 1'b1;
    rd(8'h03, 32'h20, "R8 edge capture");
    wr(8'h03, 32'h20);
    rd(8'h03, 32'h0, "R8 edge held high no recapture");
    overflow[0] = 1'b0;
    // R8 level type recaptures while held
    @(negedge clk); underflow[1] = 1'b1;
    wr(8'h03, 32'h08);
    rd(8'h03, 32'h08, "R8 level recapture");
    underflow[1] = 1'b0;
    wr(8'h03, 32'hFF);
    rd(8'h03, 32'h0, "R9 final clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule